// File: doc/BRIEF.md
# Scan Line Counter with Trigger Capture

This block counts the horizontal lines of a video frame. Every end-of-line pulse advances a 9-bit count. A frame-start pulse clears it. If no frame-start pulse arrives, the count rolls over on its own after a configurable number of lines. A processor reads a halved copy of the count: only the upper eight bits are visible, so the value it sees changes once every two lines.

The block also watches an active-low trigger input, for example a light-gun or pen button. The input is synchronised to the clock, and a press is detected on its falling edge. On each press the visible count is copied into a capture register. That register holds its value until the next press, so software can find out which line was being drawn when the button went down.

Both the live value and the captured value are read through a small read port. The port has an address and a one-cycle read strobe, and its data is combinational. The port has no write path, so nothing a processor does can change either value.

Top module: `scanline_capture`

## Requirements
- R1: After reset, the line count and the capture register are both 0, and a read of either address returns 0.
- R2: A frame-start pulse makes the count 0 at the next clock edge. A frame-start pulse takes priority over an end-of-line pulse that arrives in the same cycle.
- R3: An end-of-line pulse without a frame-start pulse raises the count by exactly one at the next clock edge. With no pulse, the count stays as it is.
- R4: An end-of-line pulse that arrives when the count equals LINES_PER_FRAME-1 (default 261) returns the count to 0.
- R5: A read at address 0 with the strobe high returns bits 8 down to 1 of the count (the count divided by two).
- R6: A read at address 1 with the strobe high returns the capture register.
- R7: A high-to-low transition on trig_n copies the visible count into the capture register. The trigger passes through a two-flop synchroniser and an edge register, so the copy appears after the third rising clock edge following the fall, and not after the second.
- R8: One press gives exactly one capture. Holding trig_n low and then releasing it does not change the capture register, and the register keeps its value while the count moves on.
- R9: When the strobe is low, or the address is neither 0 nor 1, rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_end | input | 1 | One-cycle pulse at the end of each scan line |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| trig_n | input | 1 | Active-low trigger, asynchronous to clk |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address: 0 = live count, 1 = capture |
| rd_data | output | 8 | Read data, combinational |

## Verification
Assertions check the following on every cycle: the count stays in range, it clears, steps and wraps as required, a detected press never lasts two cycles, the capture register changes only on a press, and the port reads zero when idle.

Some behaviour can only be shown by the bench scenarios, because it depends on what happens at the pins over a longer time. These are:
- the three-edge latency from a trigger fall to the new capture value;
- the halving of the count seen at the read port;
- the fact that releasing the trigger, or holding it low for a long time, causes no further capture.

Random mixes of line, frame and trigger events are compared against a model of the count kept in the bench.

// File: rtl/scl_pkg.sv
package scl_pkg;
  // Read address map; the decoder and the bench both rely on these values.
  localparam int unsigned ADDR_LIVE = 0;
  localparam int unsigned ADDR_CAPT = 1;
endpackage

// File: rtl/scl_line_counter.sv
module scl_line_counter #(
  parameter int unsigned CNT_W           = 9,
  parameter int unsigned LINES_PER_FRAME = 262
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_end,
  input  logic             frame_start,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINES_PER_FRAME - 1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             at_last;

  assign at_last = (count_q == LAST);

  always_comb begin
    count_d = count_q;
    if (frame_start)
      count_d = '0;
    else if (line_end)
      count_d = at_last ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  assign count = count_q;

  // R4: never beyond the last line
  a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
    count_q <= LAST);
  // R2: frame start clears, with priority over line end
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> count_q == '0);
  // R3: single step per line
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_start && count_q != LAST) |=> count_q == $past(count_q) + 1'b1);
  // R3: holds without pulses
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!line_end && !frame_start) |=> $stable(count_q));
  // R4: wrap at the last line
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_start && count_q == LAST) |=> count_q == '0);
endmodule

// File: rtl/scl_trig_detect.sv
module scl_trig_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_n,
  output logic press
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= trig_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b1;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  // Falling edge of the synchronised, active-low trigger
  assign press = prev_q & ~sync_q[SYNC_STAGES-1];

  // R8: a press is a single-cycle event
  a_r8_one_cycle_press: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);
endmodule

// File: rtl/scl_capture.sv
module scl_capture #(
  parameter int unsigned VIEW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              press,
  input  logic [VIEW_W-1:0] view,
  output logic [VIEW_W-1:0] captured
);
  logic [VIEW_W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst)        cap_q <= '0;
    else if (press) cap_q <= view;
  end

  assign captured = cap_q;

  // R7: a press loads the visible count
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    press |=> cap_q == $past(view));
  // R8: otherwise the capture is held
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !press |=> $stable(cap_q));
endmodule

// File: rtl/scl_read_mux.sv
module scl_read_mux
  import scl_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned VIEW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [VIEW_W-1:0] live,
  input  logic [VIEW_W-1:0] captured,
  output logic [VIEW_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (rd_addr == ADDR_W'(ADDR_LIVE))      rd_data = live;
      else if (rd_addr == ADDR_W'(ADDR_CAPT)) rd_data = captured;
    end
  end

  // R9: idle bus reads zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rd_data == '0);
endmodule

// File: rtl/scanline_capture.sv
module scanline_capture #(
  parameter int unsigned CNT_W           = 9,
  parameter int unsigned LINES_PER_FRAME = 262,
  parameter int unsigned ADDR_W          = 2,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned VIEW_W          = CNT_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_end,
  input  logic              frame_start,
  input  logic              trig_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [VIEW_W-1:0] rd_data
);
  localparam int unsigned DROP = CNT_W - VIEW_W;

  logic [CNT_W-1:0]  count;
  logic [VIEW_W-1:0] view;
  logic [VIEW_W-1:0] captured;
  logic              press;

  scl_line_counter #(.CNT_W(CNT_W), .LINES_PER_FRAME(LINES_PER_FRAME)) u_cnt (
    .clk(clk), .rst(rst), .line_end(line_end), .frame_start(frame_start), .count(count)
  );

  // R5: reduced-resolution view drops the low bit(s)
  assign view = count[CNT_W-1:DROP];

  scl_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst(rst), .trig_n(trig_n), .press(press)
  );

  scl_capture #(.VIEW_W(VIEW_W)) u_cap (
    .clk(clk), .rst(rst), .press(press), .view(view), .captured(captured)
  );

  scl_read_mux #(.ADDR_W(ADDR_W), .VIEW_W(VIEW_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .live(view), .captured(captured), .rd_data(rd_data)
  );
endmodule

// File: tb/scanline_capture_tb.sv
`timescale 1ns/1ps
module scanline_capture_tb;
  localparam int LINES = 262;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_end = 1'b0;
  logic       frame_start = 1'b0;
  logic       trig_n = 1'b1;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  int exp_cap = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scanline_capture u_dut (
    .clk(clk), .rst(rst), .line_end(line_end), .frame_start(frame_start),
    .trig_n(trig_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int f_view(input int c);
    return (c >> 1) & 8'hFF;
  endfunction

  function automatic int f_next(input int c, input bit le, input bit fs);
    if (fs) return 0;
    if (le) return (c == LINES - 1) ? 0 : c + 1;
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called just after a falling edge; samples the combinational read data.
  task automatic read_chk(input string req, input bit en, input logic [1:0] a, input int exp);
    rd_en = en; rd_addr = a;
    #1;
    check(req, int'(rd_data), exp);
    rd_en = 1'b0;
  endtask

  task automatic tick(input bit le, input bit fs);
    @(negedge clk);
    line_end = le; frame_start = fs;
    @(negedge clk);
    line_end = 1'b0; frame_start = 1'b0;
    exp_cnt = f_next(exp_cnt, le, fs);
  endtask

  task automatic press_chk(input int hold);
    int old_cap;
    old_cap = exp_cap;
    @(negedge clk); trig_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    read_chk("R7 not yet after two edges", 1'b1, 2'd1, old_cap);
    @(negedge clk);
    exp_cap = f_view(exp_cnt);
    read_chk("R7 capture after third edge", 1'b1, 2'd1, exp_cap);
    for (int k = 0; k < hold; k++) @(negedge clk);
    read_chk("R8 held low no recapture", 1'b1, 2'd1, exp_cap);
    trig_n = 1'b1;
    for (int k = 0; k < 4; k++) @(negedge clk);
    read_chk("R8 release no capture", 1'b1, 2'd1, exp_cap);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    read_chk("R1 live after reset", 1'b1, 2'd0, 0);
    read_chk("R1 capture after reset", 1'b1, 2'd1, 0);

    // R3 and R5: halving view
    tick(1, 0);
    read_chk("R5 one line view", 1'b1, 2'd0, 0);
    tick(1, 0);
    read_chk("R5 two lines view", 1'b1, 2'd0, 1);
    tick(0, 0);
    read_chk("R3 no pulse holds", 1'b1, 2'd0, f_view(exp_cnt));
    for (int k = 0; k < 9; k++) tick(1, 0);
    read_chk("R3 eleven lines", 1'b1, 2'd0, 5);

    // R9 idle and unmapped
    read_chk("R9 strobe low", 1'b0, 2'd0, 0);
    read_chk("R9 unmapped addr 2", 1'b1, 2'd2, 0);
    read_chk("R9 unmapped addr 3", 1'b1, 2'd3, 0);

    // R2 priority
    tick(1, 1);
    read_chk("R2 frame start wins", 1'b1, 2'd0, 0);
    tick(1, 0); tick(1, 0); tick(1, 0);
    tick(1, 0);
    read_chk("R2 count after clear", 1'b1, 2'd0, 2);

    // R7, R6 capture then R8 hold while counting
    press_chk(3);
    read_chk("R6 capture value", 1'b1, 2'd1, 2);
    for (int k = 0; k < 6; k++) tick(1, 0);
    read_chk("R8 capture held while counting", 1'b1, 2'd1, 2);
    read_chk("R5 live moved on", 1'b1, 2'd0, 5);

    // R4 wrap
    tick(0, 1);
    for (int k = 0; k < LINES - 1; k++) tick(1, 0);
    read_chk("R4 last line view", 1'b1, 2'd0, 130);
    press_chk(1);
    read_chk("R6 capture at last line", 1'b1, 2'd1, 130);
    tick(1, 0);
    read_chk("R4 wrap to zero", 1'b1, 2'd0, 0);
    tick(1, 0); tick(1, 0);
    read_chk("R4 continue after wrap", 1'b1, 2'd0, 1);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 6)       tick(1, 0);
      else if (op == 6) tick(0, 1);
      else if (op == 7) tick(1, 1);
      else if (op == 8) press_chk($urandom_range(0, 5));
      else              tick(0, 0);
      read_chk("R3 random live", 1'b1, 2'd0, f_view(exp_cnt));
      read_chk("R6 random capture", 1'b1, 2'd1, exp_cap);
      read_chk("R9 random unmapped", 1'b1, 2'($urandom_range(2, 3)), 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule